// File: doc/BRIEF.md
# Dual-Line Serial Sample Reader

This block reads one conversion set out of an eight-channel converter whose results come out on two serial data lines at once. A start request arms the reader. Once the converter's busy indication is low, the reader pulls chip select low and drives a read clock from a fixed divider. On every falling edge of that clock it takes one bit from each data line. Line A carries channels 0 to 3 and line B carries channels 4 to 7. Each word is 18 bits long and arrives most significant bit first. After four words on each line, which is 72 read-clock periods, the reader raises chip select and pulses `done_o`.

The converter's first-data flag is checked at two points. It must be high at the first falling edge. It must be low by the nineteenth falling edge, because the converter drops it after the eighteenth. A wrong level at either point sets `flag_err_o` for that read.

Samples leave on a valid/ready stream, in channel order 0 to 7. A sample is offered as soon as its word has arrived and all lower channels have been accepted. While `smp_ready_i` is low, the offered sample, with its data and channel, holds still. Back-pressure never stops the read clock, because all eight words are stored. A new read is refused until all eight samples of the previous read have been accepted.

Top module: `dual_line_reader`

## Requirements
- R1: After reset, `cs_n_o` and `sclk_o` are high, and `smp_valid_o` and `done_o` are low. `sclk_o` is high whenever `cs_n_o` is high.
- R2: While `busy_i` is high, an accepted start holds the reader armed with `cs_n_o` high. `cs_n_o` falls only in the cycle after `busy_i` has been sampled low.
- R3: While `cs_n_o` is low, every read-clock high phase and low phase lasts exactly HALF_DIV system clock cycles. The only exception is the first high phase, which follows the fall of `cs_n_o`.
- R4: One read gives exactly 72 falling edges of `sclk_o`, which is 4 words × 18 bits on each line. `cs_n_o` then rises together with the last rising edge of `sclk_o`, and `done_o` is high for exactly that one cycle.
- R5: Bits are taken on falling edges and each word is most significant bit first. Word k on `line_a_i` becomes channel k, and word k on `line_b_i` becomes channel 4+k, for k = 0..3. `smp_data_o` holds the 18 bits and `smp_chan_o` holds the channel number in binary.
- R6: Each read produces exactly eight samples, with channels 0, 1, …, 7 in ascending order, and each channel appears once.
- R7: While `smp_valid_o` is high and `smp_ready_i` is low, the next cycle still has `smp_valid_o` high with the same `smp_data_o` and `smp_chan_o`.
- R8: Back-pressure does not slow the read: all 72 read-clock periods and `done_o` happen even with `smp_ready_i` held low. A start while samples of the previous read are still waiting is ignored, and `cs_n_o` stays high.
- R9: `flag_err_o` goes high if `first_flag_i` is low at the 1st falling edge or high at the 19th falling edge. It stays high until the next accepted start, and it is stable when `done_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to read the next conversion set |
| busy_i | input | 1 | Converter busy indication, high during conversion |
| line_a_i | input | 1 | Serial data line for channels 0 to 3 |
| line_b_i | input | 1 | Serial data line for channels 4 to 7 |
| first_flag_i | input | 1 | Converter first-data flag |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Read clock, idle high |
| done_o | output | 1 | One-cycle pulse when chip select rises after a read |
| flag_err_o | output | 1 | First-data flag timing error for the current read |
| smp_valid_o | output | 1 | Sample stream valid |
| smp_ready_i | input | 1 | Sample stream ready |
| smp_data_o | output | WORD_W (18) | Sample value |
| smp_chan_o | output | 3 | Sample channel number |

## Verification
The serial capture and the sample stream overlap. A word can finish on the read clock in the same cycle that the stream is stalled, or in the same cycle that a lower channel is accepted. The bench provokes this by driving `smp_ready_i` randomly during every read, and once by holding it low for a whole read and then issuing a start. It judges the result in three ways: each accepted sample must match the word the bench model shifted out for that channel, the channels must arrive in order, and the fall count, the `done_o` pulse and the ignored start must be unaffected by the stall.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_ARM   = 2'd1,
    RS_SHIFT = 2'd2,
    RS_TAIL  = 2'd3
  } rd_state_t;
endpackage

// File: rtl/sclk_div.sv
module sclk_div #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic sclk_o,
  output logic fall_stb,
  output logic rise_stb
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;
  logic             sclk_q;
  logic             wrap;

  assign wrap     = en && (cnt == LAST);
  assign fall_stb = wrap && sclk_q;
  assign rise_stb = wrap && !sclk_q;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (wrap) begin
      cnt    <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_capture.sv
module lane_capture #(
  parameter int WORD_W = 18,
  parameter int WPL    = 4,
  localparam int WI_W  = $clog2(WPL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   fall_stb,
  input  logic [1:0]             line_i,
  input  logic                   flag_i,
  output logic                   wr_o,
  output logic [WI_W-1:0]        widx_o,
  output logic [1:0][WORD_W-1:0] word_o,
  output logic                   last_o,
  output logic                   flag_err_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
  localparam logic [WI_W-1:0]  LAST_WRD = WI_W'(WPL - 1);

  logic [BIT_W-1:0] bitc;
  logic [WI_W-1:0]  widx;
  logic             word_end;

  assign word_end = fall_stb && (bitc == LAST_BIT);
  assign last_o   = word_end && (widx == LAST_WRD);

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [WORD_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (!rst_n)        sh <= '0;
      else if (fall_stb) sh <= {sh[WORD_W-2:0], line_i[l]};
    end
    assign word_o[l] = sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitc       <= '0;
      widx       <= '0;
      wr_o       <= 1'b0;
      widx_o     <= '0;
      flag_err_o <= 1'b0;
    end else begin
      wr_o <= word_end;
      if (clr) begin
        bitc       <= '0;
        widx       <= '0;
        flag_err_o <= 1'b0;
      end else if (fall_stb) begin
        // flag must be high at the first fall and low at the nineteenth (R9)
        if (bitc == '0 && widx == '0 && !flag_i)           flag_err_o <= 1'b1;
        if (bitc == '0 && widx == WI_W'(1) && flag_i)      flag_err_o <= 1'b1;
        if (word_end) begin
          bitc   <= '0;
          widx   <= widx + 1'b1;
          widx_o <= widx;
        end else begin
          bitc <= bitc + 1'b1;
        end
      end
    end
  end

  // R9: once set, the error survives until a new read clears it
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_err_o && !clr) |=> flag_err_o);
endmodule

// File: rtl/sample_emit.sv
module sample_emit #(
  parameter int WORD_W = 18,
  parameter int WPL    = 4,
  localparam int NCH   = 2 * WPL,
  localparam int CH_W  = $clog2(NCH),
  localparam int WI_W  = $clog2(WPL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr,
  input  logic [WI_W-1:0]        widx,
  input  logic [1:0][WORD_W-1:0] word,
  output logic                   valid_o,
  input  logic                   ready_i,
  output logic [WORD_W-1:0]      data_o,
  output logic [CH_W-1:0]        chan_o,
  output logic                   drained_o
);
  localparam int PTR_W = $clog2(NCH + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NCH);

  logic [WORD_W-1:0] bank [NCH];
  logic [NCH-1:0]    have;
  logic [PTR_W-1:0]  ptr;

  assign chan_o    = ptr[CH_W-1:0];
  assign drained_o = (ptr == PTR_END);
  assign valid_o   = !drained_o && have[chan_o];
  assign data_o    = bank[chan_o];

  always_ff @(posedge clk) begin
    if (wr) begin
      for (int l = 0; l < 2; l++) begin
        bank[CH_W'(l * WPL) + CH_W'(widx)] <= word[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have <= '0;
      ptr  <= PTR_END;
    end else if (clr) begin
      have <= '0;
      ptr  <= '0;
    end else begin
      if (wr) begin
        for (int l = 0; l < 2; l++) begin
          have[CH_W'(l * WPL) + CH_W'(widx)] <= 1'b1;
        end
      end
      if (valid_o && ready_i) ptr <= ptr + 1'b1;
    end
  end

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(chan_o)));

  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && chan_o != CH_W'(NCH - 1))
      |=> (!valid_o || chan_o == CH_W'($past(chan_o) + 1'b1)));
endmodule

// File: rtl/dual_line_reader.sv
module dual_line_reader
  import dlr_pkg::*;
#(
  parameter int WORD_W         = 18,
  parameter int WORDS_PER_LINE = 4,
  parameter int HALF_DIV       = 3,
  localparam int CH_W          = $clog2(2 * WORDS_PER_LINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic              line_a_i,
  input  logic              line_b_i,
  input  logic              first_flag_i,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              done_o,
  output logic              flag_err_o,
  output logic              smp_valid_o,
  input  logic              smp_ready_i,
  output logic [WORD_W-1:0] smp_data_o,
  output logic [CH_W-1:0]   smp_chan_o
);
  localparam int WI_W   = $clog2(WORDS_PER_LINE);
  localparam int TOTAL  = WORD_W * WORDS_PER_LINE;
  localparam int FC_W   = $clog2(TOTAL + 1);
  localparam int HC_W   = $clog2(HALF_DIV + 2) + 1;

  rd_state_t state;
  logic      accept, clr, div_en, fall_stb, rise_stb, last_fall, drained;
  logic      wr;
  logic [WI_W-1:0]        widx;
  logic [1:0][WORD_W-1:0] words;

  assign accept = (state == RS_IDLE) && start_i && drained;
  assign clr    = accept;
  assign div_en = (state == RS_SHIFT) || (state == RS_TAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      cs_n_o <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        RS_IDLE:  if (accept) state <= RS_ARM;
        RS_ARM:   if (!busy_i) begin
                    state  <= RS_SHIFT;
                    cs_n_o <= 1'b0;
                  end
        RS_SHIFT: if (last_fall) state <= RS_TAIL;
        RS_TAIL:  if (rise_stb) begin
                    state  <= RS_IDLE;
                    cs_n_o <= 1'b1;
                    done_o <= 1'b1;
                  end
        default:  state <= RS_IDLE;
      endcase
    end
  end

  sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .en(div_en),
    .sclk_o(sclk_o), .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  lane_capture #(.WORD_W(WORD_W), .WPL(WORDS_PER_LINE)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .fall_stb(fall_stb && state == RS_SHIFT),
    .line_i({line_b_i, line_a_i}), .flag_i(first_flag_i),
    .wr_o(wr), .widx_o(widx), .word_o(words),
    .last_o(last_fall), .flag_err_o(flag_err_o)
  );

  sample_emit #(.WORD_W(WORD_W), .WPL(WORDS_PER_LINE)) u_emit (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr(wr), .widx(widx), .word(words),
    .valid_o(smp_valid_o), .ready_i(smp_ready_i),
    .data_o(smp_data_o), .chan_o(smp_chan_o), .drained_o(drained)
  );

  // Port-level watchers for the read clock and chip select
  logic            sclk_d, seen_chg;
  logic [FC_W-1:0] fcnt;
  logic [HC_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      fcnt     <= '0;
      hcnt     <= '0;
      seen_chg <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (cs_n_o) begin
        fcnt     <= '0;
        hcnt     <= '0;
        seen_chg <= 1'b0;
      end else begin
        if (sclk_d && !sclk_o) fcnt <= fcnt + 1'b1;
        if (sclk_o != sclk_d) begin
          hcnt     <= '0;
          seen_chg <= 1'b1;
        end else if (hcnt != '1) begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  a_r2_select_after_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !$past(busy_i));

  a_r3_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && seen_chg && sclk_o != sclk_d) |-> (hcnt == HC_W'(HALF_DIV - 1)));

  a_r4_fall_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (fcnt == FC_W'(TOTAL)));

  a_r4_done_with_select: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cs_n_o && $rose(cs_n_o)));
endmodule

// File: tb/tb_dual_line_reader.sv
module tb_dual_line_reader;
  localparam int HALF = 3;
  localparam int WW   = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, busy_i = 1'b0;
  logic la = 1'b0, lb = 1'b0, flag = 1'b0;
  logic rdy = 1'b0;
  logic cs_n_o, sclk_o, done_o, flag_err_o, smp_valid_o;
  logic [WW-1:0] smp_data_o;
  logic [2:0]    smp_chan_o;

  always #5 clk = !clk;

  dual_line_reader #(.WORD_W(WW), .WORDS_PER_LINE(4), .HALF_DIV(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
    .line_a_i(la), .line_b_i(lb), .first_flag_i(flag),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .done_o(done_o), .flag_err_o(flag_err_o),
    .smp_valid_o(smp_valid_o), .smp_ready_i(rdy),
    .smp_data_o(smp_data_o), .smp_chan_o(smp_chan_o)
  );

  int checks = 0, fails = 0;
  logic [WW-1:0] wa [4];
  logic [WW-1:0] wb [4];
  logic [71:0] stra, strb;
  int fmode = 0, rmode = 0;
  int bitpos = 0, fallc = 0;
  int done_cnt = 0, got = 0, exp_ch = 0, ph_bad = 0;

  function automatic logic [WW-1:0] exp_word(input int ch);
    return (ch < 4) ? wa[ch] : wb[ch-4];
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // Converter model: bits change after read-clock rising edges
  always @(negedge cs_n_o) begin
    bitpos = 0; fallc = 0;
    la = stra[71]; lb = strb[71];
    flag = (fmode != 1);
  end
  always @(posedge sclk_o) if (!cs_n_o && bitpos < 71) begin
    bitpos++;
    la = stra[71-bitpos]; lb = strb[71-bitpos];
  end
  always @(negedge sclk_o) if (!cs_n_o) begin
    fallc++;
    if (fallc == 18 && fmode != 2) flag = 1'b0;
  end

  // Stream monitor and read-clock phase watcher
  logic stall_prev = 1'b0, ps = 1'b1, ph_ok = 1'b0;
  logic [WW-1:0] pd; logic [2:0] pc;
  int run = 0;
  always @(negedge clk) if (rst_n) begin
    if (stall_prev)
      check(smp_valid_o && smp_data_o == pd && smp_chan_o == pc,
            "R7 stalled sample changed", int'(smp_data_o), int'(pd));
    case (rmode)
      0: rdy = 1'($urandom_range(0, 1));
      1: rdy = 1'b1;
      default: rdy = 1'b0;
    endcase
    stall_prev = smp_valid_o && !rdy;
    pd = smp_data_o; pc = smp_chan_o;
    if (smp_valid_o && rdy) begin
      check(int'(smp_chan_o) == exp_ch, "R6 channel order", int'(smp_chan_o), exp_ch);
      check(smp_data_o == exp_word(int'(smp_chan_o)), "R5 sample value",
            int'(smp_data_o), int'(exp_word(int'(smp_chan_o))));
      exp_ch++; got++;
    end
    if (done_o) done_cnt++;
    if (!cs_n_o) begin
      if (sclk_o != ps) begin
        if (ph_ok && run != HALF) ph_bad++;
        ph_ok = 1'b1; run = 1;
      end else run++;
    end else ph_ok = 1'b0;
    ps = sclk_o;
  end

  task automatic do_read(input int fm, input int bcyc, input int kind, input int rm);
    int d0;
    for (int k = 0; k < 4; k++) begin
      if (kind == 1) begin
        wa[k] = (k == 0) ? 18'h3FFFF : (k == 1) ? 18'h00000 : (k == 2) ? 18'h20000 : 18'h00001;
        wb[k] = ~wa[k];
      end else begin
        wa[k] = WW'($urandom); wb[k] = WW'($urandom);
      end
    end
    stra = {wa[0], wa[1], wa[2], wa[3]};
    strb = {wb[0], wb[1], wb[2], wb[3]};
    fmode = fm; rmode = rm; got = 0; exp_ch = 0; ph_bad = 0;
    d0 = done_cnt;
    @(negedge clk); busy_i = 1'b1; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (bcyc) @(negedge clk);
    check(cs_n_o == 1'b1, "R2 select held while busy", int'(cs_n_o), 1);
    busy_i = 1'b0;
    for (int i = 0; i < 3000 && done_cnt == d0; i++) @(negedge clk);
    check(flag_err_o == (fm != 0), "R9 flag error", int'(flag_err_o), int'(fm != 0));
    check(fallc == 72, "R4 falling edges per read", fallc, 72);
    check(ph_bad == 0, "R3 read-clock phase length", ph_bad, 0);
    repeat (3) @(negedge clk);
    check(done_cnt == d0 + 1, "R4 single done pulse", done_cnt - d0, 1);
    if (rm == 2) begin
      check(got == 0 && smp_valid_o, "R8 read completed under back-pressure", got, 0);
      start_i = 1'b1; @(negedge clk); start_i = 1'b0;
      repeat (20) @(negedge clk);
      check(cs_n_o == 1'b1 && done_cnt == d0 + 1, "R8 start ignored while undrained",
            int'(cs_n_o), 1);
      rmode = 0;
    end
    for (int i = 0; i < 3000 && got < 8; i++) @(negedge clk);
    check(got == 8, "R6 eight samples", got, 8);
    repeat (2) @(negedge clk);
    check(!smp_valid_o, "R6 no extra sample", int'(smp_valid_o), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n_o == 1'b1, "R1 reset select", int'(cs_n_o), 1);
    check(sclk_o == 1'b1, "R1 reset clock", int'(sclk_o), 1);
    check(!smp_valid_o, "R1 reset valid", int'(smp_valid_o), 0);
    check(!done_o, "R1 reset done", int'(done_o), 0);
    do_read(0, 5, 1, 1);
    do_read(0, 1, 0, 0);
    do_read(1, 3, 0, 0);
    do_read(2, 2, 0, 1);
    do_read(0, 4, 0, 2);
    for (int n = 0; n < 6; n++)
      do_read(0, 1 + int'($urandom_range(0, 8)), 0, 0);
    finish_run();
  end
endmodule